// File: doc/BRIEF.md
# Rectangle Table Refill Engine

This block loads rectangles of a two-dimensional address lookup table from memory without processor help. Software places a chain of descriptors in memory. Each descriptor gives a rectangle of table slots, the table it targets and a pointer to an array of 32-bit page addresses. Software starts the engine by writing the address of the first descriptor into the descriptor register. The engine reads each descriptor through a single read port that allows one outstanding request. It then reads the data array one word at a time and writes each word into one slot, sweeping the rectangle row by row. It stops at the descriptor whose link field is zero.

The expected driver sequence is: write 0 to the descriptor register to clear any earlier transaction, wait until the status register shows READY, then write the chain address. Completion, and any fault found in a descriptor, is recorded in an 8-bit interrupt status field. That field is cleared by writing back the bits that were read. A read-only information register reports how many engines and tables the block has.

Top module: `refill_engine`

## Requirements
- R1: After reset, the status register (address 1) reads 0x1 (READY only). The interrupt status (address 2) and the interrupt enable (address 3) both read 0, and `irq` is low.
- R2: The information register (address 4) reads the engine count (1) in bits [28:24] and the table count (parameter NUM_LUT) in bits [20:16]. All other bits read 0.
- R3: A descriptor is five 32-bit words starting at a 16-byte aligned address. The byte offsets are:
  - +0: link to the next descriptor.
  - +4: first corner, x in [15:0] and y in [31:16].
  - +8: last corner, x in [15:0] and y in [31:16].
  - +12: control word, with the start bit in [0] and the table id in [15:8].
  - +16: data array address.
  Writing a nonzero, 16-byte aligned address to the descriptor register (address 0) while READY starts the walk.
- R4: Data array entry k is written to slot x = x0 + (k mod w), y = y0 + (k div w), where w = x1-x0+1. Each write appears as one `lutWrEn` cycle carrying the table id, x, y and the entry.
- R5: The engine follows link fields until it finishes a descriptor whose link is 0. A descriptor with its start bit clear writes no slot, and the chain continues past it.
- R6: While a walk is active, READY reads 0. After a successful chain, status reads 0x7 (bit0 READY, bit1 VALID, bit2 DONE).
- R7: Interrupt status bits are set as follows:
  - bit0 sets when a descriptor finishes.
  - bit1 sets when the last descriptor finishes.
  Writing 1s to the interrupt status clears those bits. A set in the same cycle wins over the clear.
- R8: `irq` is high exactly when the interrupt status AND the interrupt enable is nonzero. With an enable of 0x7E, bit0 and bit7 alone do not raise `irq`.
- R9: A descriptor is rejected, and no slot of it is written, if any of these holds:
  - x1 < x0 or y1 < y0.
  - A last corner lies outside the table (x1 ≥ 2^X_W or y1 ≥ 2^Y_W).
  - The table id is ≥ NUM_LUT.
  On rejection, interrupt bit2 sets, the walk stops, and status reads 0x9 (READY and ERROR in bit3).
- R10: A misaligned descriptor address stops the walk with status 0x9 before any slot of that descriptor is written:
  - A misaligned kick value or a misaligned link sets interrupt bit3.
  - A misaligned data array address sets interrupt bit4.
- R11: A nonzero write to the descriptor register while a walk is active is ignored.
- R12: Writing 0 to the descriptor register cancels the walk. No table write happens in that cycle or afterwards. Status returns to 0x1 once any outstanding read has returned, and no interrupt bit is set by the cancel. In idle, writing 0 clears VALID, DONE and ERROR.
- R13: `memRdEn` is a one-cycle request, and no new request is issued until `memRdValid` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 3 | Register write address |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 3 | Register read address |
| regRdData | output | 32 | Register read data (combinational) |
| memRdEn | output | 1 | Memory read request, one cycle |
| memAddr | output | 32 | Byte address of the requested word |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| lutWrEn | output | 1 | Table slot write strobe |
| lutId | output | LUT_W | Target table |
| lutX | output | X_W | Slot column |
| lutY | output | Y_W | Slot row |
| lutData | output | 32 | Page address written into the slot |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that only one read is outstanding, and that no table write follows a cancel. They also check that DONE never appears without READY and VALID, that ERROR excludes VALID and DONE, and that the slot counter never steps past the rectangle's last corner. Only the bench scenarios can show the exact row-major placement of data into slots, link following and start-bit skipping, and the error codes for each kind of bad descriptor. The same holds for the partial fill left behind by a cancel and for the masking effect of the enable pattern, because each of these depends on memory contents prepared by the bench.

// File: rtl/refill_pkg.sv
package refill_pkg;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] REG_DESC   = 3'd0;
  localparam logic [REG_AW-1:0] REG_STAT   = 3'd1;
  localparam logic [REG_AW-1:0] REG_IRQ    = 3'd2;
  localparam logic [REG_AW-1:0] REG_IRQEN  = 3'd3;
  localparam logic [REG_AW-1:0] REG_HWINFO = 3'd4;

  localparam int IRQ_W    = 8;
  localparam int IRQ_FILL = 0;
  localparam int IRQ_LAST = 1;
  localparam int IRQ_RECT = 2;
  localparam int IRQ_DMIS = 3;
  localparam int IRQ_AMIS = 4;

  localparam int DESC_WORDS = 5;
  localparam int NUM_ENG    = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DWAIT, S_CHECK, S_EREQ, S_EWAIT, S_DEND, S_DRAIN
  } walkState_t;

  typedef struct packed {
    logic kick;
    logic capture;
    logic beginRect;
    logic stepSlot;
    logic followNext;
    logic selEnt;
  } dpCmd_t;

  typedef struct packed {
    logic kickZero;
    logic kickMis;
    logic lastWord;
    logic rectBad;
    logic nextMis;
    logic dataMis;
    logic nextZero;
    logic startSet;
    logic lastSlot;
  } dpFlag_t;

endpackage

// File: rtl/refill_dpath.sv
module refill_dpath
  import refill_pkg::*;
#(
  parameter int X_W     = 8,
  parameter int Y_W     = 8,
  parameter int NUM_LUT = 2,
  parameter int LUT_W   = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [31:0]      kickAddr,
  input  logic [31:0]      memRdData,
  output logic [31:0]      memAddr,
  output logic [X_W-1:0]   lutX,
  output logic [Y_W-1:0]   lutY,
  output logic [LUT_W-1:0] lutId,
  output dpFlag_t          flg
);

  localparam logic [16:0] X_LIM = 17'(1 << X_W);
  localparam logic [16:0] Y_LIM = 17'(1 << Y_W);

  logic [31:0] curDesc, nextPtr, dataPtr, entPtr;
  logic [2:0]  wordIdx;
  logic [15:0] c0x, c0y, c1x, c1y, xCur, yCur;
  logic        startBit;
  logic [7:0]  lutField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDesc  <= '0;
      nextPtr  <= '0;
      dataPtr  <= '0;
      entPtr   <= '0;
      wordIdx  <= '0;
      c0x      <= '0;
      c0y      <= '0;
      c1x      <= '0;
      c1y      <= '0;
      xCur     <= '0;
      yCur     <= '0;
      startBit <= 1'b0;
      lutField <= '0;
    end else begin
      if (cmd.kick) begin
        curDesc <= kickAddr;
        wordIdx <= '0;
      end
      if (cmd.capture) begin
        case (wordIdx)
          3'd0: nextPtr <= memRdData;
          3'd1: {c0y, c0x} <= memRdData;
          3'd2: {c1y, c1x} <= memRdData;
          3'd3: begin
            startBit <= memRdData[0];
            lutField <= memRdData[15:8];
          end
          default: dataPtr <= memRdData;
        endcase
        wordIdx <= wordIdx + 3'd1;
      end
      if (cmd.beginRect) begin
        xCur   <= c0x;
        yCur   <= c0y;
        entPtr <= dataPtr;
      end
      if (cmd.stepSlot) begin
        if (xCur == c1x) begin
          xCur <= c0x;
          yCur <= yCur + 16'd1;
        end else begin
          xCur <= xCur + 16'd1;
        end
        entPtr <= entPtr + 32'd4;
      end
      if (cmd.followNext) begin
        curDesc <= nextPtr;
        wordIdx <= '0;
      end
    end
  end

  always_comb begin
    flg.kickZero = (kickAddr == 32'd0);
    flg.kickMis  = (kickAddr[3:0] != 4'd0);
    flg.lastWord = (wordIdx == 3'(DESC_WORDS - 1));
    flg.rectBad  = (c1x < c0x) || (c1y < c0y) ||
                   ({1'b0, c1x} >= X_LIM) || ({1'b0, c1y} >= Y_LIM) ||
                   (32'(lutField) >= 32'(NUM_LUT));
    flg.nextMis  = (nextPtr[3:0] != 4'd0);
    flg.dataMis  = (dataPtr[3:0] != 4'd0);
    flg.nextZero = (nextPtr == 32'd0);
    flg.startSet = startBit;
    flg.lastSlot = (xCur == c1x) && (yCur == c1y);
  end

  assign memAddr = cmd.selEnt ? entPtr : (curDesc + {27'd0, wordIdx, 2'b00});
  assign lutX    = xCur[X_W-1:0];
  assign lutY    = yCur[Y_W-1:0];
  assign lutId   = lutField[LUT_W-1:0];

  // R4: the sweep never steps beyond the last corner of the rectangle
  a_r4_step_inside: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepSlot |-> (!((xCur == c1x) && (yCur == c1y)) && xCur <= c1x && yCur <= c1y));

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             descWr,
  input  logic             memRdValid,
  input  dpFlag_t          flg,
  output dpCmd_t           cmd,
  output logic             memRdEn,
  output logic             lutWrEn,
  output logic             stReady,
  output logic             stValid,
  output logic             stDone,
  output logic             stErr,
  output logic [IRQ_W-1:0] irqSet
);

  walkState_t state, nxt;
  logic setErr, setOk, clrFlags, abort, rdPending;

  always_comb begin
    nxt      = state;
    cmd      = '0;
    memRdEn  = 1'b0;
    lutWrEn  = 1'b0;
    irqSet   = '0;
    setErr   = 1'b0;
    setOk    = 1'b0;
    clrFlags = 1'b0;
    abort    = descWr && flg.kickZero && (state != S_IDLE);
    case (state)
      S_IDLE: begin
        if (descWr) begin
          if (flg.kickZero) begin
            clrFlags = 1'b1;
          end else if (flg.kickMis) begin
            setErr           = 1'b1;
            irqSet[IRQ_DMIS] = 1'b1;
          end else begin
            clrFlags = 1'b1;
            cmd.kick = 1'b1;
            nxt      = S_DREQ;
          end
        end
      end
      S_DREQ: begin
        memRdEn = 1'b1;
        nxt     = S_DWAIT;
      end
      S_DWAIT: begin
        if (memRdValid) begin
          cmd.capture = 1'b1;
          nxt = flg.lastWord ? S_CHECK : S_DREQ;
        end
      end
      S_CHECK: begin
        if (flg.rectBad || flg.nextMis || flg.dataMis) begin
          setErr           = 1'b1;
          irqSet[IRQ_RECT] = flg.rectBad;
          irqSet[IRQ_DMIS] = flg.nextMis;
          irqSet[IRQ_AMIS] = flg.dataMis;
          nxt              = S_IDLE;
        end else if (flg.startSet) begin
          cmd.beginRect = 1'b1;
          nxt           = S_EREQ;
        end else begin
          nxt = S_DEND;
        end
      end
      S_EREQ: begin
        memRdEn    = 1'b1;
        cmd.selEnt = 1'b1;
        nxt        = S_EWAIT;
      end
      S_EWAIT: begin
        cmd.selEnt = 1'b1;
        if (memRdValid) begin
          lutWrEn = 1'b1;
          if (flg.lastSlot) nxt = S_DEND;
          else begin
            cmd.stepSlot = 1'b1;
            nxt          = S_EREQ;
          end
        end
      end
      S_DEND: begin
        irqSet[IRQ_FILL] = 1'b1;
        if (flg.nextZero) begin
          irqSet[IRQ_LAST] = 1'b1;
          setOk            = 1'b1;
          nxt              = S_IDLE;
        end else begin
          cmd.followNext = 1'b1;
          nxt            = S_DREQ;
        end
      end
      S_DRAIN: begin
        if (memRdValid) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
    if (abort) begin
      cmd      = '0;
      memRdEn  = 1'b0;
      lutWrEn  = 1'b0;
      irqSet   = '0;
      setErr   = 1'b0;
      setOk    = 1'b0;
      clrFlags = 1'b1;
      nxt = ((state == S_DWAIT || state == S_EWAIT || state == S_DRAIN) && !memRdValid)
            ? S_DRAIN : S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      stValid   <= 1'b0;
      stDone    <= 1'b0;
      stErr     <= 1'b0;
      rdPending <= 1'b0;
    end else begin
      state <= nxt;
      if (clrFlags) begin
        stValid <= 1'b0;
        stDone  <= 1'b0;
        stErr   <= 1'b0;
      end
      if (setErr) begin
        stErr   <= 1'b1;
        stValid <= 1'b0;
        stDone  <= 1'b0;
      end
      if (setOk) begin
        stValid <= 1'b1;
        stDone  <= 1'b1;
      end
      if (memRdEn) rdPending <= 1'b1;
      else if (memRdValid) rdPending <= 1'b0;
    end
  end

  assign stReady = (state == S_IDLE);

  // R13: a new request only after the previous one was answered
  a_r13_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !rdPending);

  // R12: a cancel is never followed by a table write
  a_r12_no_write_after_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (descWr && flg.kickZero) |=> !lutWrEn);

  // R6: DONE only together with READY and VALID
  a_r6_done_with_ready: assert property (@(posedge clk) disable iff (!rstN)
    stDone |-> (stReady && stValid && !stErr));

  // R9: ERROR excludes VALID and DONE
  a_r9_error_excludes_done: assert property (@(posedge clk) disable iff (!rstN)
    stErr |-> (!stValid && !stDone));

endmodule

// File: rtl/refill_engine.sv
module refill_engine
  import refill_pkg::*;
#(
  parameter int X_W     = 8,
  parameter int Y_W     = 8,
  parameter int NUM_LUT = 2,
  localparam int LUT_W  = (NUM_LUT > 1) ? $clog2(NUM_LUT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [31:0]       regWrData,
  input  logic [REG_AW-1:0] regRdAddr,
  output logic [31:0]       regRdData,
  output logic              memRdEn,
  output logic [31:0]       memAddr,
  input  logic              memRdValid,
  input  logic [31:0]       memRdData,
  output logic              lutWrEn,
  output logic [LUT_W-1:0]  lutId,
  output logic [X_W-1:0]    lutX,
  output logic [Y_W-1:0]    lutY,
  output logic [31:0]       lutData,
  output logic              irq
);

  localparam logic [31:0] HW_INFO = {3'd0, 5'(NUM_ENG), 3'd0, 5'(NUM_LUT), 16'd0};

  dpCmd_t           cmd;
  dpFlag_t          flg;
  logic             descWr, stReady, stValid, stDone, stErr;
  logic [IRQ_W-1:0] irqSet, irqClr, irqStat, irqEn;

  assign descWr = regWrEn && (regWrAddr == REG_DESC);

  refill_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .descWr     (descWr),
    .memRdValid (memRdValid),
    .flg        (flg),
    .cmd        (cmd),
    .memRdEn    (memRdEn),
    .lutWrEn    (lutWrEn),
    .stReady    (stReady),
    .stValid    (stValid),
    .stDone     (stDone),
    .stErr      (stErr),
    .irqSet     (irqSet)
  );

  refill_dpath #(
    .X_W     (X_W),
    .Y_W     (Y_W),
    .NUM_LUT (NUM_LUT),
    .LUT_W   (LUT_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .kickAddr  (regWrData),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .lutX      (lutX),
    .lutY      (lutY),
    .lutId     (lutId),
    .flg       (flg)
  );

  assign lutData = memRdData;
  assign irqClr  = (regWrEn && regWrAddr == REG_IRQ) ? regWrData[IRQ_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqStat <= '0;
      irqEn   <= '0;
    end else begin
      irqStat <= (irqStat & ~irqClr) | irqSet;
      if (regWrEn && regWrAddr == REG_IRQEN) irqEn <= regWrData[IRQ_W-1:0];
    end
  end

  assign irq = |(irqStat & irqEn);

  always_comb begin
    case (regRdAddr)
      REG_STAT:   regRdData = {28'd0, stErr, stDone, stValid, stReady};
      REG_IRQ:    regRdData = {24'd0, irqStat};
      REG_IRQEN:  regRdData = {24'd0, irqEn};
      REG_HWINFO: regRdData = HW_INFO;
      default:    regRdData = '0;
    endcase
  end

  // R7: a completion set survives a same-cycle clear
  a_r7_last_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    irqSet[IRQ_LAST] |=> irqStat[IRQ_LAST]);

  // R11: no new walk starts while one is active
  a_r11_busy_no_kick: assert property (@(posedge clk) disable iff (!rstN)
    (!stReady && descWr) |-> !cmd.kick);

endmodule

// File: tb/refill_engine_bench.sv
module refill_engine_bench;

  localparam int XW = 4;
  localparam int YW = 4;
  localparam int NL = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [2:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        memRdEn;
  logic [31:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        lutWrEn;
  logic [0:0]  lutId;
  logic [XW-1:0] lutX;
  logic [YW-1:0] lutY;
  logic [31:0] lutData;
  logic        irq;

  refill_engine #(.X_W(XW), .Y_W(YW), .NUM_LUT(NL)) u_refill_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .lutWrEn(lutWrEn), .lutId(lutId), .lutX(lutX),
    .lutY(lutY), .lutData(lutData), .irq(irq)
  );

  always #4 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [31:0] lutMem [NL][1<<YW][1<<XW];
  logic [31:0] expLut [NL][1<<YW][1<<XW];
  int memLat = 1;
  int cnt = 0;
  logic [31:0] pAddr = '0;
  int wrCount = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) begin
    memRdValid <= 1'b0;
    if (cnt != 0) begin
      if (cnt == 1) begin
        memRdValid <= 1'b1;
        memRdData  <= mem[pAddr[11:2]];
      end
      cnt <= cnt - 1;
    end
    if (memRdEn) begin
      pAddr <= memAddr;
      cnt   <= memLat;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int l = 0; l < NL; l++)
        for (int y = 0; y < (1<<YW); y++)
          for (int x = 0; x < (1<<XW); x++) lutMem[l][y][x] <= '0;
      wrCount <= 0;
    end else if (lutWrEn) begin
      lutMem[lutId][lutY][lutX] <= lutData;
      wrCount <= wrCount + 1;
    end
  end

  function automatic logic [31:0] val(int tag, int k);
    return {8'hC0, 8'(tag), 16'(k)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    regRdAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic putDesc(int a, int nxt, int x0, int y0, int x1, int y1,
                         int start, int lut, int dat);
    mem[(a>>2)+0] = 32'(nxt);
    mem[(a>>2)+1] = {16'(y0), 16'(x0)};
    mem[(a>>2)+2] = {16'(y1), 16'(x1)};
    mem[(a>>2)+3] = {16'd0, 8'(lut), 7'd0, 1'(start)};
    mem[(a>>2)+4] = 32'(dat);
  endtask

  task automatic putData(int dat, int n, int tag);
    for (int k = 0; k < n; k++) mem[(dat>>2)+k] = val(tag, k);
  endtask

  task automatic expectRect(int lut, int x0, int y0, int x1, int y1, int tag, int limit);
    int k = 0;
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        if (k < limit) expLut[lut][y][x] = val(tag, k);
        k++;
      end
  endtask

  task automatic cmpLut(string req);
    int bad = 0;
    for (int l = 0; l < NL; l++)
      for (int y = 0; y < (1<<YW); y++)
        for (int x = 0; x < (1<<XW); x++)
          if (lutMem[l][y][x] !== expLut[l][y][x]) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  task automatic waitReady();
    logic [31:0] s;
    int n = 0;
    do begin
      @(negedge clk);
      rd(3'd1, s);
      n++;
    end while (s[0] == 1'b0 && n < 5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base, n;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int l = 0; l < NL; l++)
      for (int y = 0; y < (1<<YW); y++)
        for (int x = 0; x < (1<<XW); x++) expLut[l][y][x] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 info register
    rd(3'd1, d); chk("R1 status", d, 32'h1);
    rd(3'd2, d); chk("R1 irqstat", d, 32'h0);
    rd(3'd3, d); chk("R1 irqen", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(3'd4, d); chk("R2 hwinfo", d, 32'h0102_0000);
    wr(3'd3, 32'h7E);

    // R3 R4 single descriptor
    putDesc(32'h100, 0, 1, 2, 3, 4, 1, 0, 32'h400);
    putData(32'h400, 9, 2);
    expectRect(0, 1, 2, 3, 4, 2, 9);
    wr(3'd0, 32'h100);
    rd(3'd1, d); chk("R6 busy", d, 32'h0);
    waitReady();
    rd(3'd1, d); chk("R6 done", d, 32'h7);
    cmpLut("R4 single rect");
    chk("R3 write count", 32'(wrCount), 32'd9);
    rd(3'd2, d); chk("R7 irq bits", d, 32'h03);
    chk("R8 irq high", 32'(irq), 32'h1);
    wr(3'd2, 32'h03);
    rd(3'd2, d); chk("R7 ack", d, 32'h0);
    chk("R8 irq low", 32'(irq), 32'h0);

    // R5 chain with skipped descriptor
    memLat = 3;
    putDesc(32'h100, 32'h140, 0, 0, 15, 0, 1, 1, 32'h400);
    putData(32'h400, 16, 'h31);
    putDesc(32'h140, 32'h180, 5, 5, 6, 6, 0, 0, 32'h500);
    putData(32'h500, 4, 'h32);
    putDesc(32'h180, 0, 7, 9, 7, 9, 1, 0, 32'h600);
    putData(32'h600, 1, 'h33);
    expectRect(1, 0, 0, 15, 0, 'h31, 16);
    expectRect(0, 7, 9, 7, 9, 'h33, 1);
    base = wrCount;
    wr(3'd0, 32'h100);
    waitReady();
    rd(3'd1, d); chk("R5 chain status", d, 32'h7);
    cmpLut("R5 chain contents");
    chk("R5 chain writes", 32'(wrCount - base), 32'd17);
    wr(3'd3, 32'h00);
    chk("R8 masked all", 32'(irq), 32'h0);
    wr(3'd3, 32'h7E);
    wr(3'd2, 32'h02);
    rd(3'd2, d); chk("R7 partial ack", d, 32'h01);
    chk("R8 fill bit masked", 32'(irq), 32'h0);
    wr(3'd2, 32'h01);

    // R9 bad rectangle mid chain
    putDesc(32'h100, 32'h140, 0, 10, 1, 10, 1, 0, 32'h400);
    putData(32'h400, 2, 'h41);
    putDesc(32'h140, 32'h180, 5, 0, 3, 0, 1, 0, 32'h500);
    putDesc(32'h180, 0, 0, 12, 0, 12, 1, 0, 32'h600);
    putData(32'h600, 1, 'h43);
    expectRect(0, 0, 10, 1, 10, 'h41, 2);
    wr(3'd0, 32'h100);
    waitReady();
    rd(3'd1, d); chk("R9 status", d, 32'h9);
    rd(3'd2, d); chk("R9 irq bits", d, 32'h05);
    chk("R9 irq high", 32'(irq), 32'h1);
    cmpLut("R9 chain stopped");
    wr(3'd2, 32'h05);
    putDesc(32'h100, 0, 0, 0, 0, 0, 1, 2, 32'h400);
    wr(3'd0, 32'h100);
    waitReady();
    rd(3'd2, d); chk("R9 table id range", d, 32'h04);
    wr(3'd2, 32'h04);
    putDesc(32'h100, 0, 0, 0, 16, 0, 1, 0, 32'h400);
    wr(3'd0, 32'h100);
    waitReady();
    rd(3'd2, d); chk("R9 corner range", d, 32'h04);
    wr(3'd2, 32'h04);

    // R10 misalignment
    base = wrCount;
    wr(3'd0, 32'h104);
    rd(3'd1, d); chk("R10 kick status", d, 32'h9);
    rd(3'd2, d); chk("R10 kick irq", d, 32'h08);
    wr(3'd2, 32'h08);
    putDesc(32'h100, 0, 0, 0, 0, 0, 1, 0, 32'h408);
    wr(3'd0, 32'h100);
    waitReady();
    rd(3'd2, d); chk("R10 data irq", d, 32'h10);
    wr(3'd2, 32'h10);
    putDesc(32'h100, 32'h148, 0, 0, 0, 0, 1, 0, 32'h400);
    wr(3'd0, 32'h100);
    waitReady();
    rd(3'd2, d); chk("R10 link irq", d, 32'h08);
    rd(3'd1, d); chk("R10 link status", d, 32'h9);
    chk("R10 no writes", 32'(wrCount - base), 32'd0);
    wr(3'd2, 32'h08);
    wr(3'd0, 32'h0);
    rd(3'd1, d); chk("R12 idle clear", d, 32'h1);
    cmpLut("R10 table unchanged");

    // R11 busy write ignored
    memLat = 4;
    putDesc(32'h100, 0, 0, 1, 15, 4, 1, 1, 32'h400);
    putData(32'h400, 64, 'h61);
    putDesc(32'h200, 0, 0, 15, 15, 15, 1, 0, 32'h800);
    putData(32'h800, 16, 'h62);
    expectRect(1, 0, 1, 15, 4, 'h61, 64);
    base = wrCount;
    wr(3'd0, 32'h100);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h200);
    waitReady();
    rd(3'd1, d); chk("R11 status", d, 32'h7);
    chk("R11 write count", 32'(wrCount - base), 32'd64);
    cmpLut("R11 only first chain");
    wr(3'd2, 32'h03);

    // R12 cancel
    putDesc(32'h100, 0, 0, 11, 15, 14, 1, 0, 32'h400);
    putData(32'h400, 64, 'h71);
    base = wrCount;
    wr(3'd0, 32'h100);
    repeat (120) @(negedge clk);
    wr(3'd0, 32'h0);
    n = wrCount - base;
    repeat (40) @(negedge clk);
    chk("R12 no writes after cancel", 32'(wrCount - base), 32'(n));
    chk("R12 partial", 32'((n > 0) && (n < 64)), 32'h1);
    rd(3'd1, d); chk("R12 ready", d, 32'h1);
    rd(3'd2, d); chk("R12 no irq", d, 32'h0);
    expectRect(0, 0, 11, 15, 14, 'h71, n);
    cmpLut("R12 row-major prefix");

    // R13 walk after drain, R4 second table
    putDesc(32'h1C0, 0, 10, 10, 11, 11, 1, 1, 32'h600);
    putData(32'h600, 4, 'h81);
    expectRect(1, 10, 10, 11, 11, 'h81, 4);
    wr(3'd0, 32'h1C0);
    waitReady();
    rd(3'd1, d); chk("R13 status after restart", d, 32'h7);
    cmpLut("R13 restart contents");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule